// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing register layer of a simple serial port. It decodes zero-wait-state APB transfers into a fixed five-word register window, keeps a control word and a status word, and buffers bytes arriving from a separate serial receiver in a small receive queue. Writes to the data word are passed on to a separate transmitter as one-cycle byte strobes.

Software turns reception and transmission on through the control word. Reading the data word takes the oldest received byte from the queue. The status word reports whether bytes are waiting, how full the queue is, and whether a byte was lost. A single interrupt line pulses for one clock when an enabled receive or transmit event occurs.

Top module: `uart_apb_front`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the status word reads 0x0000_0006 (transmit shift empty at bit 1 and transmit queue empty at bit 2), reading the data word returns 0, and irq_o and tx_valid_o are low.
- R2: The control word at offset 0x08 takes all 32 bits of any write and reads them back unchanged. Bit 0 enables receive, bit 1 enables transmit, bit 2 enables the receive interrupt and bit 3 enables the transmit interrupt.
- R3: The status word at offset 0x04 is read-only. A write to it changes no bit of it.
- R4: The offsets 0x0C and 0x10, and every other offset not in R2, R3 or R5, read as 0. Writes to them change no register.
- R5: A write to the data word at offset 0x00 or 0x03 with transmit enabled raises tx_valid_o for exactly one cycle, in the cycle after the access edge, with tx_data_o equal to pwdata_i[7:0]. With transmit disabled no strobe is produced.
- R6: A byte offered on rx_valid_i is stored only when receive is enabled. Storing a byte sets status bit 0 (data ready).
- R7: Reading the data word at offset 0x00 or 0x03 returns the oldest stored byte in bits 7:0 and removes it from the queue. Status bit 0 clears when that read empties the queue. A read from an empty queue returns 0 and leaves bit 0 clear.
- R8: The queue holds DEPTH (16) bytes. Status bit 8 is set while it holds at least DEPTH/2 bytes, status bit 10 is set while it is full, and rx_ready_o is low while it is full.
- R9: A byte offered while receive is enabled and the queue is full is dropped. It sets status bit 4 (overrun), and that bit stays set until reset.
- R10: Every stored byte with the receive interrupt enabled produces a one-cycle high on irq_o in the following cycle. A dropped byte produces none.
- R11: Every forwarded transmit byte with the transmit interrupt enabled produces a one-cycle high on irq_o in the following cycle.
- R12: A receive event and a transmit event in the same cycle produce a single one-cycle pulse.
- R13: pready_o is always high and pslverr_o is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W | Byte offset into the window |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, valid in the access phase |
| pready_o | output | 1 | Transfer complete, tied high |
| pslverr_o | output | 1 | Error response, tied low |
| rx_valid_i | input | 1 | Receiver offers a byte |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive queue has room |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 8 | Byte to transmit |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A corrupted queue pointer or count shows at the ports on the next data-word read as a byte out of order, or a wrong value in status bits 0, 8 or 10. That read can be made in the cycle after the fault. A control word that is stuck or loses bits shows in the very next read of offset 0x08, and indirectly as a missing or extra tx_valid_o or irq_o pulse one cycle after the next event. A lost overrun flag stays visible in status bit 4 for the rest of the run, so any later status read exposes it.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DATA_B = 8'h03;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;

  // status bit positions
  localparam int ST_DRDY   = 0;
  localparam int ST_TSEMP  = 1;
  localparam int ST_TQEMP  = 2;
  localparam int ST_OVR    = 4;
  localparam int ST_RHALF  = 8;
  localparam int ST_RFULL  = 10;

  // control bit positions
  localparam int CT_RXEN   = 0;
  localparam int CT_TXEN   = 1;
  localparam int CT_RXIE   = 2;
  localparam int CT_TXIE   = 3;
endpackage

// File: rtl/uart_fe_rxq.sv
module uart_fe_rxq #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  logic do_push, do_pop;
  assign do_push = push_i && (cnt_q != FULL_CNT);
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_evt_i,
  input  logic tx_evt_i,
  output logic irq_o
);
  logic irq_q;
  // events in one cycle merge into one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= rx_evt_i | tx_evt_i;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_apb_front.sv
module uart_apb_front
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HALF  = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              overrun_q;
  logic              tx_valid_q;
  logic [7:0]        tx_data_q;

  logic [7:0]       off;
  logic             acc, wr_acc, rd_acc, is_data;
  logic             rx_en, tx_en, rx_ie, tx_ie;
  logic             q_push, q_pop, q_full, q_empty;
  logic [7:0]       q_dout;
  logic [CNT_W-1:0] rx_count;
  logic             rx_evt, tx_evt;
  logic [31:0]      status_w;

  assign off     = 8'(paddr_i);
  assign acc     = psel_i && penable_i;
  assign wr_acc  = acc && pwrite_i;
  assign rd_acc  = acc && !pwrite_i;
  assign is_data = (off == OFF_DATA) || (off == OFF_DATA_B);

  assign rx_en = ctrl_q[CT_RXEN];
  assign tx_en = ctrl_q[CT_TXEN];
  assign rx_ie = ctrl_q[CT_RXIE];
  assign tx_ie = ctrl_q[CT_TXIE];

  assign q_push = rx_valid_i && rx_en && !q_full;
  assign q_pop  = rd_acc && is_data && !q_empty;

  uart_fe_rxq #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .din_i   (rx_data_i),
    .pop_i   (q_pop),
    .dout_o  (q_dout),
    .count_o (rx_count),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      overrun_q  <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (wr_acc && off == OFF_CTRL) ctrl_q <= pwdata_i;
      if (rx_valid_i && rx_en && q_full) overrun_q <= 1'b1;
      tx_valid_q <= tx_evt;
      if (tx_evt) tx_data_q <= pwdata_i[7:0];
    end
  end

  assign tx_evt = wr_acc && is_data && tx_en;
  assign rx_evt = q_push && rx_ie;

  uart_fe_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_evt_i (rx_evt),
    .tx_evt_i (tx_evt && tx_ie),
    .irq_o    (irq_o)
  );

  always_comb begin
    status_w           = '0;
    status_w[ST_DRDY]  = !q_empty;
    status_w[ST_TSEMP] = 1'b1;
    status_w[ST_TQEMP] = 1'b1;
    status_w[ST_OVR]   = overrun_q;
    status_w[ST_RHALF] = (rx_count >= CNT_W'(HALF));
    status_w[ST_RFULL] = q_full;
  end

  always_comb begin
    prdata_o = '0;
    if (is_data)              prdata_o = q_empty ? 32'h0 : {24'h0, q_dout};
    else if (off == OFF_STAT) prdata_o = status_w;
    else if (off == OFF_CTRL) prdata_o = ctrl_q;
  end

  assign pready_o   = 1'b1;
  assign pslverr_o  = 1'b0;
  assign rx_ready_o = !q_full;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
endmodule

// File: rtl/uart_apb_front_chk.sv
module uart_apb_front_chk #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic              irq_o,
  input logic              pready_o,
  input logic              pslverr_o,
  input logic [31:0]       ctrl_q,
  input logic [CNT_W-1:0]  rx_count,
  input logic              overrun_q
);
  logic data_off, ctrl_wr, data_rd;
  assign data_off = (paddr_i == ADDR_W'(0)) || (paddr_i == ADDR_W'(3));
  assign ctrl_wr  = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(8));
  assign data_rd  = psel_i && penable_i && !pwrite_i && data_off;

  assert_resp_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_wr) |-> $stable(ctrl_q));

  assert_tx_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(psel_i && penable_i && pwrite_i && data_off));

  assert_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(data_rd) && $past(rx_count) == CNT_W'(1) && !$past(rx_valid_i))
      |-> rx_count == '0);

  assert_ovr_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_q) |-> $past(rx_valid_i && !rx_ready_o));

  assert_ovr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(overrun_q) |-> 1'b0);

  assert_irq_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rx_valid_i || (psel_i && penable_i && pwrite_i)));
endmodule

bind uart_apb_front uart_apb_front_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_apb_front_test.sv
`timescale 1ns/1ps
module uart_apb_front_test;
  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [AW-1:0] paddr_i = '0;
  logic [31:0]   pwdata_i = '0;
  logic [31:0]   prdata_o;
  logic          pready_o, pslverr_o;
  logic          rx_valid_i = 1'b0;
  logic [7:0]    rx_data_i = '0;
  logic          rx_ready_o, tx_valid_o, irq_o;
  logic [7:0]    tx_data_o;

  int n_chk = 0, n_bad = 0, irq_seen = 0;
  logic [7:0] exp_q[$];
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_apb_front uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for transmit strobes, counter for irq pulses
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (tx_valid_o) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R5: actual strobe %h expected none", tx_data_o);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (tx_data_o !== e) begin
            n_bad++;
            $display("FAIL R5: actual %h expected %h", tx_data_o, e);
          end
        end
      end
      if (irq_o) irq_seen++;
    end
  end

  task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    penable_i = 1;
    @(posedge clk_i);
    #1 psel_i = 0; penable_i = 0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 0; paddr_i = a;
    @(negedge clk_i);
    penable_i = 1;
    #1 d = prdata_o;
    @(posedge clk_i);
    #1 psel_i = 0; penable_i = 0;
  endtask

  task automatic tx_send(input logic [AW-1:0] a, input logic [31:0] d, input bit expect_out);
    if (expect_out) exp_q.push_back(d[7:0]);
    apb_wr(a, d);
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1; rx_data_i = b;
    @(posedge clk_i);
    #1 rx_valid_i = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    settle();

    // R1 reset state
    apb_rd(5'h04, r); chk("R1 status", r, 32'h6);
    apb_rd(5'h08, r); chk("R1 control", r, 32'h0);
    apb_rd(5'h00, r); chk("R1 data", r, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid_o}, 32'h0);
    chk("R13 pready/pslverr", {30'b0, pready_o, pslverr_o}, 32'h2);

    // R2 control readback
    apb_wr(5'h08, 32'hFFFF_FFF0); apb_rd(5'h08, r); chk("R2 ctrl ones", r, 32'hFFFF_FFF0);
    apb_wr(5'h08, 32'h8000_1230); apb_rd(5'h08, r); chk("R2 ctrl mix", r, 32'h8000_1230);

    // R3 status read-only
    apb_wr(5'h04, 32'hFFFF_FFFF); apb_rd(5'h04, r); chk("R3 status write", r, 32'h6);

    // R4 unsupported offsets
    apb_wr(5'h0C, 32'hFFFF_FFFF); apb_rd(5'h0C, r); chk("R4 scaler", r, 32'h0);
    apb_wr(5'h10, 32'hFFFF_FFFF); apb_rd(5'h10, r); chk("R4 debug", r, 32'h0);
    apb_wr(5'h14, 32'hFFFF_FFFF); apb_rd(5'h14, r); chk("R4 unmapped", r, 32'h0);
    apb_rd(5'h08, r); chk("R4 ctrl untouched", r, 32'h8000_1230);
    apb_rd(5'h04, r); chk("R4 status untouched", r, 32'h6);

    // R5 transmit disabled then enabled
    apb_wr(5'h08, 32'h0);
    tx_send(5'h00, 32'h55, 0); settle();
    apb_wr(5'h08, 32'h2);
    base = irq_seen;
    tx_send(5'h00, 32'h1A5, 1);
    tx_send(5'h03, 32'hFF3C, 1);
    tx_send(5'h01, 32'h77, 0);   // not a data offset
    settle();
    chk("R5 queue drained", exp_q.size(), 0);
    chk("R11 no irq when disabled", irq_seen - base, 0);

    // R11 transmit interrupt
    apb_wr(5'h08, 32'hA);
    base = irq_seen;
    tx_send(5'h00, 32'h42, 1); settle();
    chk("R11 tx irq", irq_seen - base, 1);

    // R6 receive disabled
    apb_wr(5'h08, 32'h0);
    rx_put(8'h11); settle();
    apb_rd(5'h04, r); chk("R6 rx disabled", r, 32'h6);

    // R6/R7 receive enabled, order, both data offsets, empty read
    apb_wr(5'h08, 32'h1);
    base = irq_seen;
    rx_put(8'hA1); rx_put(8'hB2); rx_put(8'hC3); settle();
    chk("R10 no irq when disabled", irq_seen - base, 0);
    apb_rd(5'h04, r); chk("R6 data ready", r, 32'h7);
    apb_rd(5'h00, r); chk("R7 first", r, 32'hA1);
    apb_rd(5'h03, r); chk("R7 second", r, 32'hB2);
    apb_rd(5'h04, r); chk("R7 still ready", r, 32'h7);
    apb_rd(5'h00, r); chk("R7 third", r, 32'hC3);
    apb_rd(5'h04, r); chk("R7 ready cleared", r, 32'h6);
    apb_rd(5'h00, r); chk("R7 empty read", r, 32'h0);
    apb_rd(5'h04, r); chk("R7 ready stays clear", r, 32'h6);

    // R8/R9/R10 fill, half, full, overrun
    apb_wr(5'h08, 32'h5);
    base = irq_seen;
    for (int i = 0; i < 8; i++) rx_put(8'h30 + 8'(i));
    settle();
    apb_rd(5'h04, r); chk("R8 half", r, 32'h107);
    for (int i = 8; i < 16; i++) rx_put(8'h30 + 8'(i));
    settle();
    chk("R10 rx irq count", irq_seen - base, 16);
    apb_rd(5'h04, r); chk("R8 full", r, 32'h507);
    chk("R8 rx_ready low", {31'b0, rx_ready_o}, 32'h0);
    base = irq_seen;
    rx_put(8'hEE); settle();
    chk("R10 no irq on drop", irq_seen - base, 0);
    apb_rd(5'h04, r); chk("R9 overrun", r, 32'h517);
    for (int i = 0; i < 16; i++) begin
      apb_rd(5'h00, r); chk("R9 kept bytes", r, 32'h30 + 32'(i));
    end
    apb_rd(5'h00, r); chk("R9 dropped byte", r, 32'h0);
    apb_rd(5'h04, r); chk("R9 sticky", r, 32'h16);
    chk("R8 rx_ready high", {31'b0, rx_ready_o}, 32'h1);

    // R12 simultaneous events
    apb_wr(5'h08, 32'hF);
    base = irq_seen;
    exp_q.push_back(8'h99);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = 5'h00; pwdata_i = 32'h99;
    @(negedge clk_i);
    penable_i = 1; rx_valid_i = 1; rx_data_i = 8'h5A;
    @(posedge clk_i);
    #1 psel_i = 0; penable_i = 0; rx_valid_i = 0;
    settle();
    chk("R12 merged pulse", irq_seen - base, 1);
    apb_rd(5'h00, r); chk("R12 rx byte", r, 32'h5A);
    chk("R5 final queue", exp_q.size(), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule